// File: doc/BRIEF.md
# Framed Word Deserializer with Self-Alignment

This block turns a recovered serial bit stream back into 16-bit parallel words. Bits arrive one at a time, qualified by an enable pulse from the clock-recovery logic in front of it. On the line, every word is wrapped in a frame of 18 bits. The frame opens with a start bit, carries the 16 payload bits least significant bit first, and closes with a stop bit. No line coding is applied, so the payload is passed through exactly as sent.

After reset the block does not know where frames begin. It keeps a sliding view of the most recent 18 bits and tests one candidate alignment at a time. A candidate that shows the expected start and stop bits in eight frames in a row is accepted, and the block declares lock. A candidate that fails is dropped, and the test point moves one bit later, wrapping around the frame length. The search works on live, arbitrary payload, so the sender never has to pause for training patterns.

Once locked, each well-framed word is presented with a one-cycle valid strobe. A framing error raises a one-cycle error pulse. Four framing errors in a row cause the block to release lock and search again.

Top module: `framed_deser`

## Requirements
- R1: A frame is 18 bits: start bit = 1, then payload bit 0 through bit 15 (least significant first), then stop bit = 0. For an accepted frame, `word_data` equals the payload exactly.
- R2: `bit_in` is sampled only in cycles where `bit_en` is 1. Its value in any other cycle has no effect on outputs.
- R3: Lock is reached after 8 consecutive correctly framed words at one candidate alignment. Starting from any bit offset in random payload, lock is reached within 30 word periods, with no training pattern.
- R4: While searching, a failed framing check moves the candidate alignment one bit later, wrapping modulo 18. A passing check keeps the alignment.
- R5: `word_valid` is a one-cycle pulse, asserted only while `locked` is 1 and only for correctly framed words. The frame that completes lock is itself presented as valid.
- R6: While locked, a single framing error (wrong start or stop bit) pulses `frame_err` for one cycle. It produces no `word_valid` and keeps lock. Any good frame clears the run of errors.
- R7: While locked, 4 consecutive framing errors clear `locked`, with `frame_err` pulsed on the fourth. The search then restarts and lock is regained on good data.
- R8: A constant-0 or constant-1 line never produces lock.
- R9: Synchronous active-high `rst` clears `locked`, `word_valid`, `frame_err` and all counters on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Recovered serial data bit |
| word_data | output | 16 | Last accepted payload word |
| word_valid | output | 1 | One-cycle strobe for a new accepted word |
| locked | output | 1 | Frame alignment found |
| frame_err | output | 1 | One-cycle pulse on a framing error while locked |

## Verification
The search is started from two different bit offsets inside a random payload stream, which shows that alignment is found without training and not just from a lucky phase. A table of extreme payloads (all zeros, all ones, alternating bits, single bits at either end) tells a correct bit order and pass-through apart from a reversed or shifted word. The same table injects bad start bits and bad stop bits up to three in a row, which separates the single-error path from loss of lock. A fourth consecutive error, constant-level lines, and inverted garbage on idle `bit_in` cycles then exercise lock release, false-lock immunity and the enable qualification.

// File: rtl/fdl_pkg.sv
package fdl_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } lock_state_e;

  function automatic int frame_len(input int word_w);
    return word_w + 2;
  endfunction

endpackage

// File: rtl/fdl_bit_window.sv
module fdl_bit_window #(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame_view
);

  logic [FRAME_W-2:0] hist_q;

  // newest bit sits at the top, oldest at bit 0
  assign frame_view = {bit_in, hist_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (bit_en) begin
      hist_q <= frame_view[FRAME_W-1:1];
    end
  end

endmodule

// File: rtl/fdl_phase_ctr.sv
module fdl_phase_ctr #(
  parameter int FRAME_W = 18,
  localparam int PW     = $clog2(FRAME_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          slip,
  output logic          chk_stb,
  output logic [PW-1:0] phase
);

  localparam logic [PW-1:0] LAST = PW'(FRAME_W - 1);

  logic [PW-1:0] phase_q;

  assign phase   = phase_q;
  assign chk_stb = bit_en && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (bit_en) begin
      if (phase_q == LAST) begin
        // holding on a failed candidate tests the next bit offset
        phase_q <= slip ? LAST : '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fdl_frame_check.sv
module fdl_frame_check #(
  parameter int WORD_W     = 16,
  localparam int FRAME_W   = WORD_W + 2
) (
  input  logic [FRAME_W-1:0] frame_view,
  output logic               frame_ok,
  output logic [WORD_W-1:0]  payload
);

  // oldest bit is the start marker, newest bit is the stop marker
  assign frame_ok = frame_view[0] && !frame_view[FRAME_W-1];

  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_pay
    assign payload[gi] = frame_view[gi+1];
  end

endmodule

// File: rtl/fdl_lock_ctrl.sv
module fdl_lock_ctrl
  import fdl_pkg::*;
#(
  parameter int LOCK_RUN = 8,
  parameter int LOSS_RUN = 4,
  localparam int GW      = $clog2(LOCK_RUN + 1),
  localparam int EW      = $clog2(LOSS_RUN + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        chk_stb,
  input  logic        frame_ok,
  output logic        slip,
  output logic        load_word,
  output lock_state_e state,
  output logic        valid_q,
  output logic        err_q
);

  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_RUN - 1);
  localparam logic [EW-1:0] BAD_LAST  = EW'(LOSS_RUN - 1);

  lock_state_e   state_q;
  logic [GW-1:0] good_q;
  logic [EW-1:0] bad_q;

  assign state     = state_q;
  assign slip      = chk_stb && !frame_ok && (state_q == ST_SEARCH);
  assign load_word = chk_stb && frame_ok &&
                     ((state_q == ST_LOCKED) || (good_q == GOOD_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SEARCH;
      good_q  <= '0;
      bad_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= load_word;
      err_q   <= 1'b0;
      if (chk_stb) begin
        unique case (state_q)
          ST_SEARCH: begin
            if (!frame_ok) begin
              good_q <= '0;
            end else if (good_q == GOOD_LAST) begin
              state_q <= ST_LOCKED;
              good_q  <= '0;
              bad_q   <= '0;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end
          ST_LOCKED: begin
            if (frame_ok) begin
              bad_q <= '0;
            end else begin
              err_q <= 1'b1;
              if (bad_q == BAD_LAST) begin
                state_q <= ST_SEARCH;
                bad_q   <= '0;
                good_q  <= '0;
              end else begin
                bad_q <= bad_q + 1'b1;
              end
            end
          end
          default: state_q <= ST_SEARCH;
        endcase
      end
    end
  end

endmodule

// File: rtl/framed_deser.sv
module framed_deser
  import fdl_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int LOCK_RUN = 8,
  parameter int LOSS_RUN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              locked,
  output logic              frame_err
);

  localparam int FRAME_W = frame_len(WORD_W);
  localparam int PW      = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame_view;
  logic               frame_ok;
  logic [WORD_W-1:0]  payload;
  logic               chk_stb;
  logic [PW-1:0]      phase;
  logic               slip;
  logic               load_word;
  lock_state_e        state;
  logic               valid_q;
  logic               err_q;
  logic [WORD_W-1:0]  data_q;

  fdl_bit_window #(.FRAME_W(FRAME_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .frame_view (frame_view)
  );

  fdl_frame_check #(.WORD_W(WORD_W)) u_chk_frm (
    .frame_view (frame_view),
    .frame_ok   (frame_ok),
    .payload    (payload)
  );

  fdl_phase_ctr #(.FRAME_W(FRAME_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .slip    (slip),
    .chk_stb (chk_stb),
    .phase   (phase)
  );

  fdl_lock_ctrl #(.LOCK_RUN(LOCK_RUN), .LOSS_RUN(LOSS_RUN)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .chk_stb   (chk_stb),
    .frame_ok  (frame_ok),
    .slip      (slip),
    .load_word (load_word),
    .state     (state),
    .valid_q   (valid_q),
    .err_q     (err_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (load_word) begin
      data_q <= payload;
    end
  end

  assign word_data  = data_q;
  assign word_valid = valid_q;
  assign locked     = (state == ST_LOCKED);
  assign frame_err  = err_q;

endmodule

// File: rtl/fdl_checker.sv
module fdl_checker #(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          locked,
  input logic          word_valid,
  input logic          frame_err,
  input logic          chk_stb,
  input logic          frame_ok,
  input logic [PW-1:0] phase
);

  p_valid_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> locked);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  p_err_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
    !(frame_err && word_valid));

  p_lock_word_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> word_valid);

  p_unlock_err_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(locked) && !$past(rst)) |-> frame_err);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> (!word_valid && !frame_err && $stable(locked)));

  p_slip_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (chk_stb && !frame_ok && !locked) |=> (phase == $past(phase)));

  p_keep_align_r4: assert property (@(posedge clk) disable iff (rst)
    (chk_stb && (frame_ok || locked)) |=> (phase == '0));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!locked && !word_valid && !frame_err));

endmodule

bind framed_deser fdl_checker #(.PW(PW)) u_fdl_checker (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .locked     (locked),
  .word_valid (word_valid),
  .frame_err  (frame_err),
  .chk_stb    (chk_stb),
  .frame_ok   (frame_ok),
  .phase      (phase)
);

// File: tb/framed_deser_tb_top.sv
module framed_deser_tb_top;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        bit_en;
  logic        bit_in;
  logic [15:0] word_data;
  logic        word_valid;
  logic        locked;
  logic        frame_err;

  int n_chk  = 0;
  int n_fail = 0;
  int n_stray_valid = 0;

  logic [15:0] lfsr = 16'hACE1;
  logic        obs_v, obs_l, obs_e;
  logic [15:0] obs_d;

  // {start, stop, payload, expected valid, expected error}
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 1'b0, 16'h0000, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'hA5A5, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h5A5A, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0001, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h8000, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'h1234, 1'b0, 1'b1},
    {1'b0, 1'b0, 16'h4321, 1'b0, 1'b1},
    {1'b1, 1'b1, 16'h0F0F, 1'b0, 1'b1},
    {1'b1, 1'b0, 16'hBEEF, 1'b1, 1'b0}
  };

  always #(CLK_NS/2) clk = ~clk;

  framed_deser dut_i (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .word_data  (word_data),
    .word_valid (word_valid),
    .locked     (locked),
    .frame_err  (frame_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] next_rand(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // one bit per two cycles; the idle cycle carries the inverted bit as garbage
  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = ~b;
    if (word_valid && !locked) n_stray_valid++;
  endtask

  task automatic send_frame(input logic st, input logic sp, input logic [15:0] pay);
    send_bit(st);
    for (int i = 0; i < 16; i++) send_bit(pay[i]);
    send_bit(sp);
    obs_v = word_valid;
    obs_d = word_data;
    obs_l = locked;
    obs_e = frame_err;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // random junk bits, then random frames until lock; returns frames used
  task automatic seek_lock(input int junk, output int used);
    used = 0;
    for (int j = 0; j < junk; j++) begin
      lfsr = next_rand(lfsr);
      send_bit(lfsr[0]);
    end
    obs_l = 1'b0;
    while (!obs_l && used < 30) begin
      lfsr = next_rand(lfsr);
      send_frame(1'b1, 1'b0, lfsr);
      used++;
    end
    check("R3 lock within 30 words", {31'd0, obs_l}, 32'd1);
    check("R5 locking word valid", {31'd0, obs_v}, 32'd1);
    check("R1 locking word data", {16'd0, obs_d}, {16'd0, lfsr});
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int used;
    rst = 1'b1;
    bit_en = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset locked", {31'd0, locked}, 32'd0);
    check("R9 reset valid", {31'd0, word_valid}, 32'd0);
    check("R9 reset err", {31'd0, frame_err}, 32'd0);

    // R3, R4: lock from an arbitrary offset in random payload
    seek_lock(7, used);

    // table walk: payload extremes and single framing errors (R1, R2, R6)
    for (int k = 0; k < 10; k++) begin
      send_frame(VEC[k][19], VEC[k][18], VEC[k][17:2]);
      check("R6 valid per table", {31'd0, obs_v}, {31'd0, VEC[k][1]});
      check("R6 err per table", {31'd0, obs_e}, {31'd0, VEC[k][0]});
      check("R6 lock held", {31'd0, obs_l}, 32'd1);
      if (VEC[k][1]) check("R1 R2 table data", {16'd0, obs_d}, {16'd0, VEC[k][17:2]});
    end

    // R7: four consecutive errors release lock
    for (int k = 1; k <= 4; k++) begin
      send_frame(1'b1, 1'b1, 16'h3C3C);
      check("R7 err pulse", {31'd0, obs_e}, 32'd1);
      check("R7 lock state", {31'd0, obs_l}, (k < 4) ? 32'd1 : 32'd0);
    end
    seek_lock(0, used);

    // R9: reset while locked
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid-run reset locked", {31'd0, locked}, 32'd0);
    check("R9 mid-run reset valid", {31'd0, word_valid}, 32'd0);

    // R8: constant lines never lock
    for (int j = 0; j < 300; j++) send_bit(1'b0);
    check("R8 constant zero", {31'd0, locked}, 32'd0);
    for (int j = 0; j < 300; j++) send_bit(1'b1);
    check("R8 constant one", {31'd0, locked}, 32'd0);

    // R3, R4: second search from a different offset
    do_reset();
    seek_lock(13, used);
    send_frame(1'b1, 1'b0, 16'hC001);
    check("R1 after relock data", {16'd0, obs_d}, 32'h0000C001);

    check("R5 no valid while unlocked", n_stray_valid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule